// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Decoder

This block sits in front of a small synchronous SRAM array and turns the control pins sampled on each rising clock edge into one cycle decision. The pins are three chip enables, a processor-side and a controller-side address strobe, burst advance, global write, byte-write enable, per-byte selects, sleep and output enable. The decision is one of: deselect, sleep, begin read, begin write, continue (next burst address) read or write, and suspend (same address) read or write. A registered base address and a 2-bit linear burst counter form the address the cycle uses. The block applies per-byte write strobes to the array and reads it through a pipeline register.

Read data is presented on a separate output with a bus-enable flag that an outer pad ring turns into a tri-state driver. The flag follows the output-enable pin with no clock in the path. It is forced off for every cycle that is not a read, and writes in particular keep the bus released.

Top module: `sburst_cycle_dec`

## Requirements
- R1: With sleep_i high at a clock edge, the cycle is sleep (code 1). Nothing is written, the address register is unchanged and the bus enable is low, whatever the other inputs are.
- R2: The device is selected only when ce1_ni=0, ce2_i=1 and ce3_ni=0. An accepted strobe (adsp_ni low with ce1_ni low, or adsc_ni low) seen while the device is not selected gives a deselect cycle (code 0). No write occurs, the address is unchanged and the bus enable is low.
- R3: With ce1_ni high, adsp_ni is ignored. If adsc_ni is low the cycle is a deselect. If adsc_ni is high, the cycle follows the burst rules of R7.
- R4: When selected with adsp_ni low, the cycle is a begin read (code 2) at addr_i, regardless of gw_ni, bwe_ni and bw_ni.
- R5: When selected with adsp_ni high and adsc_ni low, addr_i is loaded. The cycle is a begin write (code 3) if the combined write is active and a begin read (code 2) otherwise.
- R6: The combined write is active when gw_ni=0, or when bwe_ni=0 and at least one bit of bw_ni is 0. It is inactive otherwise.
- R7: With both strobes inactive, adv_ni=0 gives a continue cycle: read code 4, write code 5. The two low address bits step 00→01→10→11→00 and the upper bits are kept. adv_ni=1 gives a suspend cycle at the same address: read code 6, write code 7. In both cases the combined write picks read or write.
- R8: In a write cycle (codes 3, 5, 7), wr_strb_o is all ones if gw_ni=0. Otherwise bit k is 1 exactly when bwe_ni=0 and bw_ni[k]=0. Byte k of the addressed word takes dq_i[8k+7:8k] when its strobe is set. In all other cycles wr_strb_o is zero.
- R9: After the edge of a read cycle (codes 2, 4, 6), dq_o holds the stored word at addr_o. dq_o is unchanged by other cycles. In a read cycle, dq_oe_o equals the inverse of oe_ni and follows it with no clock edge.
- R10: dq_oe_o is low in every write cycle, whatever oe_ni is.
- R11: After reset, cyc_o=0, addr_o=0, wr_strb_o=0, dq_o=0 and dq_oe_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep request, active high |
| ce1_ni | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| adsp_ni | input | 1 | Processor address strobe, active low |
| adsc_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write enable, active low |
| bw_ni | input | NB | Byte selects, active low |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| addr_i | input | AW | External address |
| dq_i | input | 8*NB | Write data |
| dq_o | output | 8*NB | Registered read data |
| dq_oe_o | output | 1 | Data bus drive enable |
| cyc_o | output | 3 | Cycle type of the last edge |
| addr_o | output | AW | Address used by the last cycle |
| wr_strb_o | output | NB | Byte strobes of the last cycle |

## Verification
Cycle type, address, byte strobes and read data each pass through one register. They are therefore due one rising edge after the controls that cause them. The bench drives each set of controls on a falling edge, lets one rising edge pass, and compares on the next falling edge. The bus enable has no register after oe_ni. After the clocked comparison, the bench inverts oe_ni in mid-cycle and checks dq_oe_o again one nanosecond later with no edge in between. This confirms both the asynchronous path and the write masking.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  typedef enum logic [2:0] {
    CYC_DESEL  = 3'd0,
    CYC_SLEEP  = 3'd1,
    CYC_RD_EXT = 3'd2,
    CYC_WR_EXT = 3'd3,
    CYC_RD_NXT = 3'd4,
    CYC_WR_NXT = 3'd5,
    CYC_RD_CUR = 3'd6,
    CYC_WR_CUR = 3'd7
  } cyc_e;

  typedef enum logic [1:0] {
    ADR_HOLD = 2'd0,
    ADR_LOAD = 2'd1,
    ADR_INC  = 2'd2
  } adr_op_e;
endpackage

// File: rtl/sbd_decode.sv
module sbd_decode
  import sbd_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          sleep_i,
  input  logic          ce1_ni,
  input  logic          ce2_i,
  input  logic          ce3_ni,
  input  logic          adsp_ni,
  input  logic          adsc_ni,
  input  logic          adv_ni,
  input  logic          gw_ni,
  input  logic          bwe_ni,
  input  logic [NB-1:0] bw_ni,
  output cyc_e          cyc_o,
  output adr_op_e       op_o,
  output logic [NB-1:0] strb_o,
  output logic          rd_o
);
  logic          sel;
  logic          wr;
  logic [NB-1:0] byte_en;
  logic          is_wr;

  always_comb begin
    sel     = ~ce1_ni & ce2_i & ~ce3_ni;
    byte_en = ~bw_ni & {NB{~bwe_ni}};
    wr      = ~gw_ni | (|byte_en);
    cyc_o   = CYC_DESEL;
    op_o    = ADR_HOLD;
    if (sleep_i) begin
      cyc_o = CYC_SLEEP;
    end else if (!adsp_ni && !ce1_ni) begin
      // processor strobe always reads
      if (sel) begin
        cyc_o = CYC_RD_EXT;
        op_o  = ADR_LOAD;
      end
    end else if (!adsc_ni) begin
      if (sel) begin
        cyc_o = wr ? CYC_WR_EXT : CYC_RD_EXT;
        op_o  = ADR_LOAD;
      end
    end else if (!adv_ni) begin
      cyc_o = wr ? CYC_WR_NXT : CYC_RD_NXT;
      op_o  = ADR_INC;
    end else begin
      cyc_o = wr ? CYC_WR_CUR : CYC_RD_CUR;
    end
    is_wr  = (cyc_o == CYC_WR_EXT) || (cyc_o == CYC_WR_NXT) || (cyc_o == CYC_WR_CUR);
    rd_o   = (cyc_o == CYC_RD_EXT) || (cyc_o == CYC_RD_NXT) || (cyc_o == CYC_RD_CUR);
    strb_o = is_wr ? (gw_ni ? byte_en : {NB{1'b1}}) : '0;
  end
endmodule

// File: rtl/sbd_burst.sv
module sbd_burst
  import sbd_pkg::*;
#(
  parameter int AW = 6,
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  adr_op_e       op_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_nxt_o,
  output logic [AW-1:0] addr_q_o
);
  localparam int UW = AW - CW;

  logic [UW-1:0] base_q, base_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    base_n = base_q;
    cnt_n  = cnt_q;
    case (op_i)
      ADR_LOAD: begin
        base_n = addr_i[AW-1:CW];
        cnt_n  = addr_i[CW-1:0];
      end
      ADR_INC:  cnt_n = cnt_q + CW'(1);
      default:  ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
    end
  end

  assign addr_nxt_o = {base_n, cnt_n};
  assign addr_q_o   = {base_q, cnt_q};

  // R7
  burst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == ADR_INC |=> cnt_q == CW'($past(cnt_q) + CW'(1)) && base_q == $past(base_q));

  // R1
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == ADR_HOLD |=> addr_q_o == $past(addr_q_o));
endmodule

// File: rtl/sbd_array.sv
module sbd_array #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic [NB-1:0]  we_i,
  input  logic           rd_i,
  input  logic [NB*BW-1:0] wdata_i,
  output logic [NB*BW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0] mem [DEPTH];
    logic [BW-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem[addr_i] <= wdata_i[g*BW +: BW];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rd_q <= '0;
      else if (rd_i) rd_q <= mem[addr_i];
    end

    assign rdata_o[g*BW +: BW] = rd_q;
  end
endmodule

// File: rtl/sburst_cycle_dec.sv
module sburst_cycle_dec
  import sbd_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  localparam int DW = 8 * NB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sleep_i,
  input  logic          ce1_ni,
  input  logic          ce2_i,
  input  logic          ce3_ni,
  input  logic          adsp_ni,
  input  logic          adsc_ni,
  input  logic          adv_ni,
  input  logic          gw_ni,
  input  logic          bwe_ni,
  input  logic [NB-1:0] bw_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic [2:0]    cyc_o,
  output logic [AW-1:0] addr_o,
  output logic [NB-1:0] wr_strb_o
);
  cyc_e          cyc_d, cyc_q;
  adr_op_e       op_d;
  logic [NB-1:0] strb_d, strb_q;
  logic          rd_d, rd_q;
  logic [AW-1:0] addr_nxt;

  sbd_decode #(.NB(NB)) u_decode (
    .sleep_i (sleep_i),
    .ce1_ni  (ce1_ni),
    .ce2_i   (ce2_i),
    .ce3_ni  (ce3_ni),
    .adsp_ni (adsp_ni),
    .adsc_ni (adsc_ni),
    .adv_ni  (adv_ni),
    .gw_ni   (gw_ni),
    .bwe_ni  (bwe_ni),
    .bw_ni   (bw_ni),
    .cyc_o   (cyc_d),
    .op_o    (op_d),
    .strb_o  (strb_d),
    .rd_o    (rd_d)
  );

  sbd_burst #(.AW(AW), .CW(2)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op_d),
    .addr_i     (addr_i),
    .addr_nxt_o (addr_nxt),
    .addr_q_o   (addr_o)
  );

  sbd_array #(.AW(AW), .NB(NB), .BW(8)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_nxt),
    .we_i    (strb_d),
    .rd_i    (rd_d),
    .wdata_i (dq_i),
    .rdata_o (dq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= CYC_DESEL;
      strb_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      cyc_q  <= cyc_d;
      strb_q <= strb_d;
      rd_q   <= rd_d;
    end
  end

  assign cyc_o     = cyc_q;
  assign wr_strb_o = strb_q;
  // oe has no clock in its path
  assign dq_oe_o   = rd_q & ~oe_ni;

  logic sel_w, wr_cyc_w;
  assign sel_w    = ~ce1_ni & ce2_i & ~ce3_ni;
  assign wr_cyc_w = (cyc_o == 3'd3) || (cyc_o == 3'd5) || (cyc_o == 3'd7);

  // R10
  wr_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cyc_w |-> !dq_oe_o);

  // R1
  sleep_cyc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> cyc_o == 3'd1 && wr_strb_o == '0 && !dq_oe_o);

  // R4
  adsp_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !adsp_ni && sel_w) |=> cyc_o == 3'd2 && addr_o == $past(addr_i));

  // R2
  deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !sel_w && (!adsc_ni || (!adsp_ni && !ce1_ni)))
      |=> cyc_o == 3'd0 && !dq_oe_o && addr_o == $past(addr_o));

  // R8
  strb_only_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_strb_o != '0) |-> wr_cyc_w);
endmodule

// File: tb/sburst_cycle_dec_tb.sv
`timescale 1ns/1ps
module sburst_cycle_dec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep, ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n;
  logic [3:0]  bw_n;
  logic [5:0]  addr;
  logic [31:0] dq_in;
  logic [31:0] dq_out;
  logic        dq_oe;
  logic [2:0]  cyc;
  logic [5:0]  addr_out;
  logic [3:0]  strb;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_mem [64];
  logic [3:0]  m_base = '0;
  logic [1:0]  m_cnt = '0;
  logic [31:0] m_dq = '0;
  logic        m_rd = 1'b0;

  always #2 clk = ~clk;

  sburst_cycle_dec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .ce1_ni(ce1_n), .ce2_i(ce2),
    .ce3_ni(ce3_n), .adsp_ni(adsp_n), .adsc_ni(adsc_n), .adv_ni(adv_n),
    .gw_ni(gw_n), .bwe_ni(bwe_n), .bw_ni(bw_n), .oe_ni(oe_n), .addr_i(addr),
    .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe), .cyc_o(cyc),
    .addr_o(addr_out), .wr_strb_o(strb)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic comb_wr(input logic gw, input logic bwe, input logic [3:0] bw);
    return !gw || (!bwe && bw != 4'hF);
  endfunction

  function automatic logic [2:0] f_cyc(input logic zz, input logic c1, input logic c2, input logic c3,
                                       input logic sp, input logic sc, input logic av, input logic w);
    logic s;
    s = !c1 && c2 && !c3;
    if (zz) return 3'd1;
    if (!sp && !c1) return s ? 3'd2 : 3'd0;
    if (!sc) return s ? (w ? 3'd3 : 3'd2) : 3'd0;
    if (!av) return w ? 3'd5 : 3'd4;
    return w ? 3'd7 : 3'd6;
  endfunction

  task automatic step(input logic zz, input logic c1, input logic c2, input logic c3,
                      input logic sp, input logic sc, input logic av, input logic gw,
                      input logic bwe, input logic [3:0] bw, input logic oe,
                      input logic [5:0] a, input logic [31:0] d);
    logic [2:0] e_cyc;
    logic [3:0] e_strb;
    logic       w, e_wr;
    string      tag;
    sleep = zz; ce1_n = c1; ce2 = c2; ce3_n = c3; adsp_n = sp; adsc_n = sc;
    adv_n = av; gw_n = gw; bwe_n = bwe; bw_n = bw; oe_n = oe; addr = a; dq_in = d;
    w = comb_wr(gw, bwe, bw);
    e_cyc = f_cyc(zz, c1, c2, c3, sp, sc, av, w);
    if (zz) tag = "R1";
    else if (!sp && !c1) tag = (e_cyc == 3'd2) ? "R4" : "R2";
    else if (!sc) tag = (e_cyc != 3'd0) ? "R5" : (c1 ? "R3" : "R2");
    else tag = c1 ? "R3" : "R7";
    if (e_cyc == 3'd2 || e_cyc == 3'd3) begin m_base = a[5:2]; m_cnt = a[1:0]; end
    else if (e_cyc == 3'd4 || e_cyc == 3'd5) m_cnt = m_cnt + 2'd1;
    e_wr   = (e_cyc == 3'd3) || (e_cyc == 3'd5) || (e_cyc == 3'd7);
    e_strb = e_wr ? (!gw ? 4'hF : (bwe ? 4'h0 : ~bw)) : 4'h0;
    m_rd   = (e_cyc == 3'd2) || (e_cyc == 3'd4) || (e_cyc == 3'd6);
    if (m_rd) m_dq = m_mem[{m_base, m_cnt}];
    for (int k = 0; k < 4; k++)
      if (e_strb[k]) m_mem[{m_base, m_cnt}][k*8 +: 8] = d[k*8 +: 8];
    @(posedge clk);
    @(negedge clk);
    chk(tag, "cycle", 32'(cyc), 32'(e_cyc));
    chk(tag, "address", 32'(addr_out), 32'({m_base, m_cnt}));
    if (!zz && (sp || c1) && e_cyc != 3'd0)
      chk("R6", "write select", 32'(cyc == 3'd3 || cyc == 3'd5 || cyc == 3'd7), 32'(w));
    chk("R8", "strobes", 32'(strb), 32'(e_strb));
    chk("R9", "read data", dq_out, m_dq);
    chk(e_wr ? "R10" : "R9", "bus enable", 32'(dq_oe), 32'(m_rd & !oe));
    oe_n = !oe;
    #1;
    chk(e_wr ? "R10" : "R9", "bus enable after oe toggle", 32'(dq_oe), 32'(m_rd & oe));
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    sleep = 0; ce1_n = 1; ce2 = 0; ce3_n = 1; adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; addr = '0; dq_in = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11 reset state, oe low to prove enable stays off
    chk("R11", "cycle", 32'(cyc), 0);
    chk("R11", "address", 32'(addr_out), 0);
    chk("R11", "strobes", 32'(strb), 0);
    chk("R11", "read data", dq_out, 0);
    chk("R11", "bus enable", 32'(dq_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill every word with begin-write cycles
    for (int a = 0; a < 64; a++)
      step(0, 0, 1, 0, 1, 0, 1, 0, 1, 4'hF, 1, 6'(a), $urandom);

    // R1 sleep beats a selected processor strobe
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, 4'h0, 0, 6'h15, 32'hDEAD_BEEF);
    // R4 processor strobe with global write low still reads
    step(0, 0, 1, 0, 0, 1, 1, 0, 0, 4'h0, 0, 6'h2E, 32'h1111_1111);
    // R7 burst wrap 10 -> 11 -> 00 -> 01, upper bits fixed
    step(0, 1, 1, 0, 1, 1, 0, 1, 1, 4'hF, 0, 6'h00, 32'h0);
    step(0, 0, 1, 0, 1, 1, 0, 1, 1, 4'hF, 0, 6'h00, 32'h0);
    step(0, 0, 1, 0, 1, 1, 0, 1, 1, 4'hF, 0, 6'h00, 32'h0);
    // R3 ce1 high: processor strobe ignored, continues burst
    step(0, 1, 0, 1, 0, 1, 0, 1, 1, 4'hF, 0, 6'h3F, 32'h0);
    // R3 ce1 high with controller strobe: deselect
    step(0, 1, 1, 0, 1, 0, 0, 0, 0, 4'h0, 0, 6'h01, 32'h0);
    // R2 ce2 low with processor strobe: deselect
    step(0, 0, 0, 0, 0, 1, 1, 1, 1, 4'hF, 0, 6'h07, 32'h0);
    // R6 bwe low but no byte selected: controller strobe reads
    step(0, 0, 1, 0, 1, 0, 1, 1, 0, 4'hF, 0, 6'h09, 32'h0);
    // R8 partial byte write, then suspend read to see it
    step(0, 0, 1, 0, 1, 0, 1, 1, 0, 4'b1010, 0, 6'h09, 32'hA5C3_7E18);
    step(0, 0, 1, 0, 1, 1, 1, 1, 1, 4'hF, 0, 6'h00, 32'h0);
    // R10 suspend write with oe low keeps bus released
    step(0, 0, 1, 0, 1, 1, 1, 0, 1, 4'hF, 0, 6'h00, 32'h0BAD_F00D);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] bw;
      bw = 4'($urandom);
      step(($urandom % 16) == 0, ($urandom % 8) == 0, ($urandom % 8) != 0,
           ($urandom % 8) == 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
           1'($urandom), ($urandom % 4) != 0, 1'($urandom), bw, 1'($urandom),
           6'($urandom), $urandom);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule